// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block keeps the interrupt flags and enable bits for a small 8-bit processor core and produces one interrupt request for the instruction sequencer. Three core sources feed it: a timer overflow pulse, an edge on an external pin, and a change detector that compares four port pins with the value the core last read from them. A bank of peripheral flags sits behind a second enable level. The bank has one enable per flag and one common peripheral enable in the control register.

Each flag latches its event whatever the enables are. Enables decide only whether a latched flag raises the request. Software clears a flag by writing the register that holds it. When the sequencer takes an interrupt it pulses `irq_take`, and that disarms the global enable. The return-from-interrupt pulse `irq_ret` arms it again. The change flag keeps setting itself while the pins differ from the last-read snapshot. The core must read the port with `port_rd` before a software clear can hold.

Top module: `irq_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, `ctl_rdata`, `per_en_rdata` and `per_flag_rdata` read 0 and `irq_req` is low.
- R2: The control register holds these bits, from bit 7 down to bit 0: global enable, peripheral enable, timer enable, pin enable, change enable, timer flag, pin flag, change flag. A write with `ctl_wr` is visible on `ctl_rdata` after the next clock edge.
- R3: A one-cycle `tmr_ovf` pulse sets the timer flag (bit 2) whatever the state of any enable.
- R4: When `pin_rise_sel` is 1, a 0-to-1 transition of `ext_pin` sets the pin flag (bit 1). When it is 0, a 1-to-0 transition sets it. The other transition direction leaves the flag unchanged.
- R5: The change flag (bit 0) sets on every cycle in which `port_pins` differ from the snapshot taken at the last `port_rd` strobe, or at reset. A software clear therefore does not hold until `port_rd` has refreshed the snapshot.
- R6: A `per_set` pulse sets the matching peripheral flag whatever the enables are. Core and peripheral flags keep their value until software writes them.
- R7: `irq_req` = global enable AND (timer flag AND timer enable, OR pin flag AND pin enable, OR change flag AND change enable, OR peripheral enable AND any peripheral flag together with its own enable).
- R8: With the peripheral enable clear, no peripheral flag can raise `irq_req`. With the global enable clear, no flag can raise it.
- R9: `irq_take` clears the global enable and `irq_ret` sets it. `irq_take` wins over `irq_ret`, and both win over a same-cycle control write.
- R10: When a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| pin_rise_sel | input | 1 | Pin edge select: 1 rising, 0 falling |
| ext_pin | input | 1 | External interrupt pin (already synchronised) |
| port_pins | input | PORT_W | Watched port pins (already synchronised) |
| port_rd | input | 1 | Port read strobe; refreshes the snapshot |
| tmr_ovf | input | 1 | Timer overflow pulse |
| per_set | input | NUM_PER | Peripheral event pulses |
| per_en_wr | input | 1 | Write strobe for peripheral enables |
| per_en_wdata | input | NUM_PER | Peripheral enable write data |
| per_en_rdata | output | NUM_PER | Peripheral enables |
| per_flag_wr | input | 1 | Write strobe for peripheral flags |
| per_flag_wdata | input | NUM_PER | Peripheral flag write data |
| per_flag_rdata | output | NUM_PER | Peripheral flags |
| irq_take | input | 1 | Sequencer has taken the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the sequencer |

## Verification
The critical overlap is a hardware set event and a software write of the same flag landing on one clock edge. The bench forces it for the timer flag and for a peripheral flag by asserting the event pulse together with a write of 0. It also forces it for the change flag by clearing it while the port mismatch persists. In each case the flag must read 1 afterwards. A second overlap is between `irq_take`, `irq_ret` and a control write in the same cycle, and there the global enable must follow the stated priority.

// File: rtl/irq_pkg.sv
// Package: shared types for the interrupt controller.
// Assumes a single 8-bit control register whose bit order is decoded by software.
package irq_pkg;
    // Control register, bit 7 first.
    typedef struct packed {
        logic gie;     // bit 7 global enable
        logic peie;    // bit 6 peripheral enable
        logic tmr_en;  // bit 5 timer enable
        logic pin_en;  // bit 4 pin enable
        logic chg_en;  // bit 3 change enable
        logic tmr_fl;  // bit 2 timer flag
        logic pin_fl;  // bit 1 pin flag
        logic chg_fl;  // bit 0 change flag
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/irq_pin_edge.sv
// Module: edge detector for the external interrupt pin.
// Assumes the pin is already synchronised to clk. Emits a one-cycle hit on
// the selected edge. The history register loads the pin during reset, so a
// static level never counts as an edge.
module irq_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    // Track the pin one cycle back; reset loads the live level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= pin;
        else        prev_q <= pin;
    end

    // Pick the edge direction requested by the select input.
    always_comb begin
        if (rise_sel) hit = pin & ~prev_q;
        else          hit = ~pin & prev_q;
    end
endmodule

// File: rtl/irq_port_watch.sv
// Module: mismatch detector for the watched port pins.
// Assumes synchronised pins. A snapshot is captured at reset and at every
// read strobe. The mismatch output stays high while any pin differs from it.
module irq_port_watch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         rd_stb,
    output logic         mismatch
);
    logic [W-1:0] snap_q;

    // Capture the last-read value on reset or on a port read.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_stb) snap_q <= pins;
    end

    // Any differing bit keeps the mismatch asserted.
    assign mismatch = |(pins ^ snap_q);
endmodule

// File: rtl/irq_periph_bank.sv
// Module: peripheral flag and enable bank.
// Each flag is set by its event pulse whatever the enables are. A software
// write loads the flags, but a same-cycle event keeps its bit set. The
// output any_hit reports a flag whose own enable is set.
module irq_periph_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pls,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    input  logic         flag_wr,
    input  logic [N-1:0] flag_wdata,
    output logic [N-1:0] en_q,
    output logic [N-1:0] flag_q,
    output logic         any_hit
);
    // Enable register: plain software load.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: the hardware event wins over the software value.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (set_pls[i]) flag_q[i] <= 1'b1;
            else if (flag_wr)    flag_q[i] <= flag_wdata[i];
        end

        // R10 / R6: an event always leaves the flag set.
        a_r10_periph_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_pls[i] |=> flag_q[i]);
        // R6: without a write, a set flag stays set.
        a_r6_periph_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !flag_wr) |=> flag_q[i]);
    end

    assign any_hit = |(flag_q & en_q);
endmodule

// File: rtl/irq_ctrl.sv
// Module: top of the two-level maskable interrupt controller.
// Holds the control register, combines core and peripheral sources into a
// single request, and handles take and return strobes on the global enable.
// Assumes all pin inputs are synchronised and event inputs are single-cycle pulses.
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int PORT_W  = 4,
    parameter int NUM_PER = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_wdata,
    output logic [CTL_W-1:0]   ctl_rdata,
    input  logic               pin_rise_sel,
    input  logic               ext_pin,
    input  logic [PORT_W-1:0]  port_pins,
    input  logic               port_rd,
    input  logic               tmr_ovf,
    input  logic [NUM_PER-1:0] per_set,
    input  logic               per_en_wr,
    input  logic [NUM_PER-1:0] per_en_wdata,
    output logic [NUM_PER-1:0] per_en_rdata,
    input  logic               per_flag_wr,
    input  logic [NUM_PER-1:0] per_flag_wdata,
    output logic [NUM_PER-1:0] per_flag_rdata,
    input  logic               irq_take,
    input  logic               irq_ret,
    output logic               irq_req
);
    ctl_t ctl_q, ctl_d;
    logic pin_hit, chg_mismatch, per_hit, core_hit;

    irq_pin_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .rise_sel (pin_rise_sel),
        .hit      (pin_hit)
    );

    irq_port_watch #(.W(PORT_W)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (port_pins),
        .rd_stb   (port_rd),
        .mismatch (chg_mismatch)
    );

    irq_periph_bank #(.N(NUM_PER)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_pls    (per_set),
        .en_wr      (per_en_wr),
        .en_wdata   (per_en_wdata),
        .flag_wr    (per_flag_wr),
        .flag_wdata (per_flag_wdata),
        .en_q       (per_en_rdata),
        .flag_q     (per_flag_rdata),
        .any_hit    (per_hit)
    );

    // Next control value: software write, then hardware sets and strobes on top.
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d = ctl_t'(ctl_wdata);
        if (tmr_ovf)      ctl_d.tmr_fl = 1'b1;
        if (pin_hit)      ctl_d.pin_fl = 1'b1;
        if (chg_mismatch) ctl_d.chg_fl = 1'b1;
        if (irq_take)     ctl_d.gie    = 1'b0;
        else if (irq_ret) ctl_d.gie    = 1'b1;
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Request combine: core sources, plus peripherals behind the second level.
    always_comb begin
        core_hit = (ctl_q.tmr_fl & ctl_q.tmr_en) |
                   (ctl_q.pin_fl & ctl_q.pin_en) |
                   (ctl_q.chg_fl & ctl_q.chg_en);
        irq_req  = ctl_q.gie & (core_hit | (ctl_q.peie & per_hit));
    end

    assign ctl_rdata = ctl_q;

    // R3 / R10: a timer pulse always leaves the flag set.
    a_r3_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctl_q.tmr_fl);
    // R4: a detected pin edge sets the pin flag.
    a_r4_pin_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hit |=> ctl_q.pin_fl);
    // R5: a persisting mismatch sets the change flag.
    a_r5_chg_sets: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mismatch |=> ctl_q.chg_fl);
    // R9: taking an interrupt disarms the global enable.
    a_r9_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !ctl_q.gie);
    // R9: a return without a take re-arms it.
    a_r9_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_take) |=> ctl_q.gie);
    // R8: the request is quiet in the cycle after a take.
    a_r8_req_off_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_req);
    // R6: without a write or a pulse, the timer flag holds.
    a_r6_tmr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !tmr_ovf) |=> (ctl_q.tmr_fl == $past(ctl_q.tmr_fl)));
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
    localparam int PW = 4;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic [7:0]    ctl_rdata;
    logic          pin_rise_sel = 1'b1;
    logic          ext_pin = 1'b0;
    logic [PW-1:0] port_pins = '0;
    logic          port_rd = 1'b0;
    logic          tmr_ovf = 1'b0;
    logic [NP-1:0] per_set = '0;
    logic          per_en_wr = 1'b0;
    logic [NP-1:0] per_en_wdata = '0;
    logic [NP-1:0] per_en_rdata;
    logic          per_flag_wr = 1'b0;
    logic [NP-1:0] per_flag_wdata = '0;
    logic [NP-1:0] per_flag_rdata;
    logic          irq_take = 1'b0;
    logic          irq_ret = 1'b0;
    logic          irq_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_ctrl #(.PORT_W(PW), .NUM_PER(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .pin_rise_sel(pin_rise_sel), .ext_pin(ext_pin),
        .port_pins(port_pins), .port_rd(port_rd), .tmr_ovf(tmr_ovf),
        .per_set(per_set), .per_en_wr(per_en_wr), .per_en_wdata(per_en_wdata),
        .per_en_rdata(per_en_rdata), .per_flag_wr(per_flag_wr),
        .per_flag_wdata(per_flag_wdata), .per_flag_rdata(per_flag_rdata),
        .irq_take(irq_take), .irq_ret(irq_ret), .irq_req(irq_req)
    );

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] pen;
        logic [7:0] pfl;
        logic       req;
    } vec_t;

    // Request truth table (R7, R8): control, peripheral enables, peripheral flags, request.
    localparam vec_t TBL [12] = '{
        '{8'h80, 8'h00, 8'h00, 1'b0},
        '{8'hA4, 8'h00, 8'h00, 1'b1},
        '{8'h24, 8'h00, 8'h00, 1'b0},
        '{8'h92, 8'h00, 8'h00, 1'b1},
        '{8'h90, 8'h00, 8'h00, 1'b0},
        '{8'h89, 8'h00, 8'h00, 1'b1},
        '{8'h86, 8'h00, 8'h00, 1'b0},
        '{8'hC0, 8'h01, 8'h01, 1'b1},
        '{8'h80, 8'h01, 8'h01, 1'b0},
        '{8'hC0, 8'h10, 8'h01, 1'b0},
        '{8'hC0, 8'hFF, 8'h80, 1'b1},
        '{8'h40, 8'hFF, 8'hFF, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; cyc(); ctl_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        // R1: reset values.
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 pen", per_en_rdata, 0);
        chk("R1 pfl", per_flag_rdata, 0);
        chk("R1 req", irq_req, 0);
        rst_n = 1'b1;
        cyc();

        // R2, R7, R8: walk the table.
        for (int i = 0; i < 12; i++) begin
            ctl_wr = 1'b1; ctl_wdata = TBL[i].ctl;
            per_en_wr = 1'b1; per_en_wdata = TBL[i].pen;
            per_flag_wr = 1'b1; per_flag_wdata = TBL[i].pfl;
            cyc();
            ctl_wr = 1'b0; per_en_wr = 1'b0; per_flag_wr = 1'b0;
            chk($sformatf("R2 ctl row %0d", i), ctl_rdata, TBL[i].ctl);
            chk($sformatf("R7 req row %0d", i), irq_req, TBL[i].req);
        end
        wr_ctl(8'h00);
        per_en_wr = 1'b1; per_en_wdata = '0; per_flag_wr = 1'b1; per_flag_wdata = '0;
        cyc(); per_en_wr = 1'b0; per_flag_wr = 1'b0;

        // R3: timer pulse sets its flag with every enable clear.
        tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
        chk("R3 tmr flag", ctl_rdata, 8'h04);
        chk("R3 no req", irq_req, 0);
        repeat (3) cyc();
        chk("R6 tmr holds", ctl_rdata, 8'h04);
        wr_ctl(8'h00);
        chk("R6 tmr cleared", ctl_rdata, 8'h00);

        // R10: pulse and write of 0 in the same cycle.
        tmr_ovf = 1'b1; ctl_wr = 1'b1; ctl_wdata = 8'h00; cyc();
        tmr_ovf = 1'b0; ctl_wr = 1'b0;
        chk("R10 tmr set wins", ctl_rdata, 8'h04);
        wr_ctl(8'h00);
        per_set = 8'h08; per_flag_wr = 1'b1; per_flag_wdata = 8'h00; cyc();
        per_set = '0; per_flag_wr = 1'b0;
        chk("R10 periph set wins", per_flag_rdata, 8'h08);
        repeat (2) cyc();
        chk("R6 periph holds", per_flag_rdata, 8'h08);
        per_flag_wr = 1'b1; per_flag_wdata = 8'h00; cyc(); per_flag_wr = 1'b0;
        chk("R6 periph cleared", per_flag_rdata, 8'h00);

        // R4: edge selection.
        pin_rise_sel = 1'b1; ext_pin = 1'b1; cyc();
        chk("R4 rise sets", ctl_rdata[1], 1);
        wr_ctl(8'h00);
        ext_pin = 1'b0; cyc();
        chk("R4 fall ignored in rise mode", ctl_rdata[1], 0);
        pin_rise_sel = 1'b0; ext_pin = 1'b1; cyc();
        chk("R4 rise ignored in fall mode", ctl_rdata[1], 0);
        ext_pin = 1'b0; cyc();
        chk("R4 fall sets", ctl_rdata[1], 1);
        wr_ctl(8'h00);

        // R5: change flag re-asserts until the port is read.
        port_pins = 4'b1010; cyc();
        chk("R5 change sets", ctl_rdata[0], 1);
        wr_ctl(8'h00);
        chk("R5 clear does not hold", ctl_rdata[0], 1);
        port_rd = 1'b1; cyc(); port_rd = 1'b0;
        wr_ctl(8'h00);
        chk("R5 clear holds after read", ctl_rdata[0], 0);
        cyc();
        chk("R5 stays clear", ctl_rdata[0], 0);

        // R9: take and return strobes.
        wr_ctl(8'hA4);
        chk("R9 armed req", irq_req, 1);
        irq_take = 1'b1; cyc(); irq_take = 1'b0;
        chk("R9 take clears gie", ctl_rdata, 8'h24);
        chk("R9 take drops req", irq_req, 0);
        irq_ret = 1'b1; cyc(); irq_ret = 1'b0;
        chk("R9 ret sets gie", ctl_rdata, 8'hA4);
        irq_take = 1'b1; irq_ret = 1'b1; cyc(); irq_take = 1'b0; irq_ret = 1'b0;
        chk("R9 take beats ret", ctl_rdata[7], 0);
        irq_ret = 1'b1; ctl_wr = 1'b1; ctl_wdata = 8'h24; cyc();
        irq_ret = 1'b0; ctl_wr = 1'b0;
        chk("R9 ret beats write", ctl_rdata, 8'hA4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule